// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block is a free-running raster timing source that advances one position per clock. It keeps a horizontal position counter and a vertical line counter. From them it decodes two active-low sync levels: a line sync at the start of every scanline, and a frame sync that starts at the top of the frame and is released halfway along a later scanline. The frame sync is released in the middle of a line, not at a line boundary.

It also produces two area qualifiers. The first marks the visible pixel rectangle. The second marks a fetch window of the same size that opens a fixed number of positions before the visible area, so that memory reads can be issued ahead of display. Single-cycle pulses on the last position of each line and of each frame tell downstream address logic when to advance. Colour generation, the memory fetch itself and the analogue stage sit outside this block.

All geometry is set by parameters. The defaults are a 1024-position line, a 312-line frame and a 640 x 256 visible area.

Top module: `vt_sync_gen`

## Requirements
- R1: `x_pos` counts up by one every clock from 0 to LINE_LEN-1 (default 1023) and then returns to 0.
- R2: `y_pos` holds its value within a line, increments when `x_pos` wraps, and returns to 0 after FRAME_LINES-1 (default 311).
- R3: `hsync_n` is 0 while `x_pos` < HS_END (default 75) and 1 otherwise. The low phase is therefore HS_END clocks on every line.
- R4: `vsync_n` is 0 from position 0 of line 0 until, but not including, position LINE_LEN/2 (default 512) of line VS_END_LINE (default 2). It is 1 at every other position.
- R5: `pix_active` is 1 exactly when VIS_Y0 <= `y_pos` < VIS_Y0+VIS_H (default lines 38 to 293) and VIS_X0 <= `x_pos` < VIS_X0+VIS_W (default positions 264 to 903). This gives VIS_W*VIS_H active clocks per frame.
- R6: `fetch_active` is 1 exactly on the visible lines of R5, at positions VIS_X0-FETCH_LEAD up to but not including VIS_X0+VIS_W-FETCH_LEAD. With the default lead of 8, this is positions 256 to 895. It therefore rises FETCH_LEAD clocks before `pix_active` on each visible line.
- R7: `line_end` is 1 for exactly the one clock where `x_pos` = LINE_LEN-1. `frame_end` is 1 for exactly the one clock where, in addition, `y_pos` = FRAME_LINES-1.
- R8: While `rst` is 1 at a rising clock edge, both counters are cleared to 0. As a result, `hsync_n` and `vsync_n` are both 0 straight after reset, and counting resumes from 0 once `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Position clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| x_pos | output | $clog2(LINE_LEN) (10) | Horizontal position |
| y_pos | output | $clog2(FRAME_LINES) (9) | Vertical line number |
| pix_active | output | 1 | Inside the visible area |
| fetch_active | output | 1 | Inside the early fetch window |
| line_end | output | 1 | Last position of a line |
| frame_end | output | 1 | Last position of a frame |

## Verification
On every cycle, the assertions check the local rules: the position step and wrap, the line hold and the line wrap, that line sync releases at HS_END, that frame sync rises only at the mid-line point of VS_END_LINE, that the fetch window opens FETCH_LEAD positions before the visible window, and that the end pulses last one clock. The totals over a frame can only be shown by the bench's scenarios: the length of each line-sync low phase, the number of frame-sync low clocks, the pixel and fetch area sizes, and the number of line pulses per frame. The same holds for the state after resets applied at random points in mid-frame.

// File: rtl/vt_pkg.sv
package vt_pkg;

    // Default raster geometry (positions per line, lines per frame).
    localparam int VT_LINE_LEN     = 1024;
    localparam int VT_FRAME_LINES  = 312;
    localparam int VT_HS_END       = 75;
    localparam int VT_VS_END_LINE  = 2;
    localparam int VT_VIS_Y0       = 38;
    localparam int VT_VIS_H        = 256;
    localparam int VT_VIS_X0       = 264;
    localparam int VT_VIS_W        = 640;
    localparam int VT_FETCH_LEAD   = 8;

    // Decoded per-position qualifiers.
    typedef struct packed {
        logic hsync_n;
        logic vsync_n;
        logic pix;
        logic fetch;
    } vt_flags_t;

endpackage

// File: rtl/vt_hcount.sv
module vt_hcount #(
    parameter int LINE_LEN = vt_pkg::VT_LINE_LEN,
    localparam int XW = $clog2(LINE_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [XW-1:0] x,
    output logic          wrap
);
    localparam logic [XW-1:0] X_LAST = XW'(LINE_LEN - 1);

    assign wrap = (x == X_LAST);

    always_ff @(posedge clk) begin
        if (rst)       x <= '0;
        else if (wrap) x <= '0;
        else           x <= x + 1'b1;
    end
endmodule

// File: rtl/vt_vcount.sv
module vt_vcount #(
    parameter int FRAME_LINES = vt_pkg::VT_FRAME_LINES,
    localparam int YW = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [YW-1:0] y,
    output logic          wrap
);
    localparam logic [YW-1:0] Y_LAST = YW'(FRAME_LINES - 1);

    assign wrap = step && (y == Y_LAST);

    always_ff @(posedge clk) begin
        if (rst)       y <= '0;
        else if (wrap) y <= '0;
        else if (step) y <= y + 1'b1;
    end
endmodule

// File: rtl/vt_decode.sv
module vt_decode #(
    parameter int LINE_LEN    = vt_pkg::VT_LINE_LEN,
    parameter int FRAME_LINES = vt_pkg::VT_FRAME_LINES,
    parameter int HS_END      = vt_pkg::VT_HS_END,
    parameter int VS_END_LINE = vt_pkg::VT_VS_END_LINE,
    parameter int VIS_Y0      = vt_pkg::VT_VIS_Y0,
    parameter int VIS_H       = vt_pkg::VT_VIS_H,
    parameter int VIS_X0      = vt_pkg::VT_VIS_X0,
    parameter int VIS_W       = vt_pkg::VT_VIS_W,
    parameter int FETCH_LEAD  = vt_pkg::VT_FETCH_LEAD,
    localparam int XW = $clog2(LINE_LEN),
    localparam int YW = $clog2(FRAME_LINES)
) (
    input  logic [XW-1:0]     x,
    input  logic [YW-1:0]     y,
    output vt_pkg::vt_flags_t flags
);
    localparam logic [XW-1:0] HS_X   = XW'(HS_END);
    localparam logic [XW-1:0] VS_X   = XW'(LINE_LEN / 2);
    localparam logic [YW-1:0] VS_Y   = YW'(VS_END_LINE);
    localparam logic [YW-1:0] ROW_LO = YW'(VIS_Y0);
    localparam logic [YW-1:0] ROW_HI = YW'(VIS_Y0 + VIS_H);
    localparam logic [XW-1:0] PIX_LO = XW'(VIS_X0);
    localparam logic [XW-1:0] PIX_HI = XW'(VIS_X0 + VIS_W);
    localparam logic [XW-1:0] FET_LO = XW'(VIS_X0 - FETCH_LEAD);
    localparam logic [XW-1:0] FET_HI = XW'(VIS_X0 + VIS_W - FETCH_LEAD);

    logic rows_ok;

    always_comb begin
        rows_ok       = (y >= ROW_LO) && (y < ROW_HI);
        flags.hsync_n = !(x < HS_X);
        flags.vsync_n = !((y < VS_Y) || ((y == VS_Y) && (x < VS_X)));
        flags.pix     = rows_ok && (x >= PIX_LO) && (x < PIX_HI);
        flags.fetch   = rows_ok && (x >= FET_LO) && (x < FET_HI);
    end
endmodule

// File: rtl/vt_sync_gen.sv
module vt_sync_gen #(
    parameter int LINE_LEN    = vt_pkg::VT_LINE_LEN,
    parameter int FRAME_LINES = vt_pkg::VT_FRAME_LINES,
    parameter int HS_END      = vt_pkg::VT_HS_END,
    parameter int VS_END_LINE = vt_pkg::VT_VS_END_LINE,
    parameter int VIS_Y0      = vt_pkg::VT_VIS_Y0,
    parameter int VIS_H       = vt_pkg::VT_VIS_H,
    parameter int VIS_X0      = vt_pkg::VT_VIS_X0,
    parameter int VIS_W       = vt_pkg::VT_VIS_W,
    parameter int FETCH_LEAD  = vt_pkg::VT_FETCH_LEAD,
    localparam int XW = $clog2(LINE_LEN),
    localparam int YW = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic [XW-1:0] x_pos,
    output logic [YW-1:0] y_pos,
    output logic          pix_active,
    output logic          fetch_active,
    output logic          line_end,
    output logic          frame_end
);
    vt_pkg::vt_flags_t flags;

    vt_hcount #(.LINE_LEN(LINE_LEN)) u_h (
        .clk(clk), .rst(rst), .x(x_pos), .wrap(line_end)
    );

    vt_vcount #(.FRAME_LINES(FRAME_LINES)) u_v (
        .clk(clk), .rst(rst), .step(line_end), .y(y_pos), .wrap(frame_end)
    );

    vt_decode #(
        .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .HS_END(HS_END),
        .VS_END_LINE(VS_END_LINE), .VIS_Y0(VIS_Y0), .VIS_H(VIS_H),
        .VIS_X0(VIS_X0), .VIS_W(VIS_W), .FETCH_LEAD(FETCH_LEAD)
    ) u_dec (
        .x(x_pos), .y(y_pos), .flags(flags)
    );

    assign hsync_n      = flags.hsync_n;
    assign vsync_n      = flags.vsync_n;
    assign pix_active   = flags.pix;
    assign fetch_active = flags.fetch;
endmodule

// File: rtl/vt_sync_chk.sv
module vt_sync_chk #(
    parameter int LINE_LEN    = vt_pkg::VT_LINE_LEN,
    parameter int FRAME_LINES = vt_pkg::VT_FRAME_LINES,
    parameter int HS_END      = vt_pkg::VT_HS_END,
    parameter int VS_END_LINE = vt_pkg::VT_VS_END_LINE,
    parameter int VIS_X0      = vt_pkg::VT_VIS_X0,
    parameter int FETCH_LEAD  = vt_pkg::VT_FETCH_LEAD,
    localparam int XW = $clog2(LINE_LEN),
    localparam int YW = $clog2(FRAME_LINES)
) (
    input logic          clk,
    input logic          rst,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic [XW-1:0] x_pos,
    input logic [YW-1:0] y_pos,
    input logic          pix_active,
    input logic          fetch_active,
    input logic          line_end,
    input logic          frame_end
);
    localparam logic [XW-1:0] XL  = XW'(LINE_LEN - 1);
    localparam logic [YW-1:0] YL  = YW'(FRAME_LINES - 1);
    localparam logic [XW-1:0] HSX = XW'(HS_END);
    localparam logic [XW-1:0] VSX = XW'(LINE_LEN / 2);
    localparam logic [YW-1:0] VSY = YW'(VS_END_LINE);
    localparam logic [XW-1:0] PX0 = XW'(VIS_X0);
    localparam logic [XW-1:0] FX0 = XW'(VIS_X0 - FETCH_LEAD);

    a_r1_x_step: assert property (@(posedge clk) disable iff (rst)
        (x_pos != XL) |=> (x_pos == $past(x_pos) + 1'b1));
    a_r1_x_wrap: assert property (@(posedge clk) disable iff (rst)
        (x_pos == XL) |=> (x_pos == '0));
    a_r2_y_hold: assert property (@(posedge clk) disable iff (rst)
        (x_pos != XL) |=> $stable(y_pos));
    a_r2_y_wrap: assert property (@(posedge clk) disable iff (rst)
        (x_pos == XL && y_pos == YL) |=> (y_pos == '0));
    a_r3_hs_release: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> (x_pos == HSX));
    a_r4_vs_release: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_n) |-> (y_pos == VSY && x_pos == VSX));
    a_r5_pix_after_fetch: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_active) |-> (x_pos == PX0 && fetch_active));
    a_r6_fetch_open: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_active) |-> (x_pos == FX0));
    a_r7_line_pulse: assert property (@(posedge clk) disable iff (rst)
        line_end |=> !line_end);
    a_r7_frame_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (line_end && y_pos == YL));
endmodule

bind vt_sync_gen vt_sync_chk #(
    .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .HS_END(HS_END),
    .VS_END_LINE(VS_END_LINE), .VIS_X0(VIS_X0), .FETCH_LEAD(FETCH_LEAD)
) u_chk (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .x_pos(x_pos), .y_pos(y_pos), .pix_active(pix_active),
    .fetch_active(fetch_active), .line_end(line_end), .frame_end(frame_end)
);

// File: tb/tb_vt_sync_gen.sv
`timescale 1ns/1ps
module tb_vt_sync_gen;
    // Reduced geometry so two whole frames fit in the run.
    localparam int L = 128, F = 40, HE = 10, VL = 2;
    localparam int Y0 = 5, H = 24, X0 = 40, W = 64, LEAD = 8;
    localparam int XW = $clog2(L), YW = $clog2(F);

    logic clk = 1'b0, rst = 1'b1;
    logic hsync_n, vsync_n, pix_active, fetch_active, line_end, frame_end;
    logic [XW-1:0] x_pos;
    logic [YW-1:0] y_pos;

    always #2.5 clk = ~clk;

    vt_sync_gen #(.LINE_LEN(L), .FRAME_LINES(F), .HS_END(HE), .VS_END_LINE(VL),
        .VIS_Y0(Y0), .VIS_H(H), .VIS_X0(X0), .VIS_W(W), .FETCH_LEAD(LEAD)) dut (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .x_pos(x_pos), .y_pos(y_pos), .pix_active(pix_active),
        .fetch_active(fetch_active), .line_end(line_end), .frame_end(frame_end));

    int n_chk = 0, n_fail = 0;
    int mx = 0, my = 0;
    bit measure = 0, finished = 0;
    int hs_run = 0, vs_cnt = 0, pix_cnt = 0, fet_cnt = 0, le_cnt = 0, fe_cnt = 0;

    function automatic bit rows_ok(int y); return y >= Y0 && y < Y0 + H; endfunction
    function automatic bit e_hs(int x); return !(x < HE); endfunction
    function automatic bit e_vs(int x, int y); return !(y < VL || (y == VL && x < L / 2)); endfunction
    function automatic bit e_pix(int x, int y); return rows_ok(y) && x >= X0 && x < X0 + W; endfunction
    function automatic bit e_fet(int x, int y); return rows_ok(y) && x >= X0 - LEAD && x < X0 + W - LEAD; endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at x=%0d y=%0d: actual %0d expected %0d", req, mx, my, act, exp);
        end
    endtask

    task automatic compare_all();
        check(int'(x_pos) == mx, "R1 x_pos", int'(x_pos), mx);
        check(int'(y_pos) == my, "R2 y_pos", int'(y_pos), my);
        check(hsync_n == e_hs(mx), "R3 hsync_n", int'(hsync_n), int'(e_hs(mx)));
        check(vsync_n == e_vs(mx, my), "R4 vsync_n", int'(vsync_n), int'(e_vs(mx, my)));
        check(pix_active == e_pix(mx, my), "R5 pix_active", int'(pix_active), int'(e_pix(mx, my)));
        check(fetch_active == e_fet(mx, my), "R6 fetch_active", int'(fetch_active), int'(e_fet(mx, my)));
        check(line_end == (mx == L - 1), "R7 line_end", int'(line_end), int'(mx == L - 1));
        check(frame_end == (mx == L - 1 && my == F - 1), "R7 frame_end",
              int'(frame_end), int'(mx == L - 1 && my == F - 1));
    endtask

    // Accumulates observed output totals; checked at line and frame ends.
    task automatic tally();
        if (!hsync_n) hs_run++;
        if (!vsync_n) vs_cnt++;
        if (pix_active) pix_cnt++;
        if (fetch_active) fet_cnt++;
        if (line_end) le_cnt++;
        if (frame_end) fe_cnt++;
        if (mx == L - 1) begin
            check(hs_run == HE, "R3 low width", hs_run, HE);
            hs_run = 0;
        end
        if (mx == L - 1 && my == F - 1) begin
            check(vs_cnt == VL * L + L / 2, "R4 low clocks", vs_cnt, VL * L + L / 2);
            check(pix_cnt == W * H, "R5 area", pix_cnt, W * H);
            check(fet_cnt == W * H, "R6 area", fet_cnt, W * H);
            check(le_cnt == F, "R7 line pulses", le_cnt, F);
            check(fe_cnt == 1, "R7 frame pulses", fe_cnt, 1);
            vs_cnt = 0; pix_cnt = 0; fet_cnt = 0; le_cnt = 0; fe_cnt = 0;
        end
    endtask

    // Called at a falling edge: drive rst for the next rising edge, then observe.
    task automatic step(bit next_rst);
        rst = next_rst;
        @(negedge clk);
        if (next_rst) begin
            mx = 0; my = 0;
        end else if (mx == L - 1) begin
            mx = 0;
            my = (my == F - 1) ? 0 : my + 1;
        end else begin
            mx++;
        end
        compare_all();
        if (measure) tally();
    endtask

    task automatic check_reset_state();
        check(x_pos == '0, "R8 x after reset", int'(x_pos), 0);
        check(y_pos == '0, "R8 y after reset", int'(y_pos), 0);
        check(!hsync_n, "R8 hsync_n after reset", int'(hsync_n), 0);
        check(!vsync_n, "R8 vsync_n after reset", int'(vsync_n), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0017));
        repeat (3) @(negedge clk);
        check_reset_state();
        compare_all();
        // Two clean frames with totals measured (R3..R7).
        measure = 1;
        tally();
        for (int i = 0; i < 2 * L * F - 1; i++) step(1'b0);
        measure = 0;
        // Resets at random mid-frame points, exact model compare every cycle.
        for (int k = 0; k < 6; k++) begin
            int n = int'($urandom_range(20, 2500));
            repeat (n) step(1'b0);
            step(1'b1);
            step(1'b1);
            check_reset_state();
        end
        // Directed: run past the mid-line frame-sync release after a reset (R4).
        repeat (VL * L + L / 2 + 4) step(1'b0);
        check(vsync_n == 1'b1, "R4 released", int'(vsync_n), 1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule